// File: doc/BRIEF.md
# Eight-Bit Core Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and turns them into vector requests. It has three event sources: a timer roll-over pulse, an external interrupt pin with a selectable active edge, and a change detector on an 8-bit input port. Software reaches an enable register, a flag register and a port snapshot through a simple register bus. The enable register carries one global enable bit and one enable bit per source.

When the global enable is set and any flagged source is also enabled, the block commits a hardware request and clears the global enable in the same cycle. A software-interrupt instruction strobe commits a request to a separate vector. The return-from-interrupt strobe sets the global enable again. Requests leave the block on a valid/ready channel. `take_vector` is the fetch address of the handler. Once `take_valid` is high, it stays high and `take_vector` stays constant until the core raises `take_ready` at an edge. After each accepted request, `take_valid` is low for at least one cycle.

During sleep, the `wake` output signals any enabled pending source, whatever the state of the global enable. The core then takes the vector if the global enable is set. If it is clear, the core resumes at its next instruction.

Top module: `irq_ctl`

## Requirements
- R1: After reset, the enable register, the flag register and the port snapshot are all zero, and `take_valid` and `wake` are low.
- R2: Register map on `reg_addr`:
  - 0 is the enable register. Bit 7 is the global enable, bit 0 enables the timer, bit 1 the port change, bit 2 the pin.
  - 1 reads the flag register ANDed bitwise with the enable register.
  - 2 reads `port_in`. A read there with `reg_rd` high loads the port snapshot at that edge.
- R3: A `tmr_ovf` pulse sets flag bit 0 at that clock edge, whether or not enable bit 0 is set.
- R4: `pin_in` passes through a two-flop synchronizer.
  - With `edge_rise`=1 a rising edge sets flag bit 2. With `edge_rise`=0 a falling edge sets it. The other edge has no effect.
  - The flag is set at the third clock edge after the pin changes.
  - The pin sets flag bit 2 whether or not its enable bit is set.
- R5: Flag bit 1 is set at an edge only when enable bit 1 is set and `port_in` differs from the port snapshot. A port change while enable bit 1 is clear sets nothing.
- R6: A write to address 1 clears each flag bit whose written bit is 0. Written 1s leave the flag unchanged. An event in the same cycle as a clearing write leaves its flag set.
- R7: When the global enable is set and (flags AND enables) is nonzero in bits 2:0, `take_valid` rises at the next edge with `take_vector`=0x08, and the global enable reads 0 from that edge on.
- R8: A `swi_stb` pulse raises `take_valid` at the next edge with `take_vector`=0x02, whatever the global enable. It is held pending if a request is already outstanding. It wins over a hardware request in the same cycle and leaves the global enable unchanged.
- R9: While `take_valid` is high and `take_ready` is low, `take_valid` and `take_vector` hold. After acceptance, `take_valid` is low for the next cycle.
- R10: A `reti_stb` pulse sets the global enable at that edge and takes priority over a bus write in the same cycle.
- R11: `wake` is high exactly when `sleep` is high and (flags AND enables) is nonzero in bits 2:0, independent of the global enable. With the global enable clear, no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | External interrupt pin (asynchronous) |
| edge_rise | input | 1 | Pin edge select: 1 rising, 0 falling |
| tmr_ovf | input | 1 | One-cycle timer roll-over pulse |
| port_in | input | 8 | Port inputs watched for change |
| sleep | input | 1 | Core is in sleep |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| swi_stb | input | 1 | Software interrupt instruction strobe |
| take_valid | output | 1 | Vector request valid |
| take_ready | input | 1 | Core accepts the request |
| take_vector | output | 8 | Handler fetch address |
| wake | output | 1 | Wake request during sleep |

## Verification
A table of enable values, timer pulses and flag-write masks shows three things. The flag register reads masked by the enables, events set flags regardless of their enable, and only written zeros clear a flag. Pin tests apply both edge polarities under both select settings, so a wrong polarity or a missing synchronizer stage gives a different result. Port tests separate a change made while disabled from one made while enabled, and check that the snapshot is reloaded. Request tests stall the channel, send a software request and a hardware request in the same cycle, and run the return strobe and sleep with the global enable clear, so priority, vector choice, global-enable handling and wake-without-vector are each shown on their own.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned GIE_BIT  = 7;
  localparam int unsigned TMR_BIT  = 0;
  localparam int unsigned CHG_BIT  = 1;
  localparam int unsigned PIN_BIT  = 2;
  localparam int unsigned SRC_N    = 3;

  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_FLAGS  = 2'd1,
    RA_PORT   = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic edge_rise,
  output logic edge_ev
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign edge_ev = edge_rise ? ( sync_q[SYNC_STAGES-1] & ~prev_q)
                             : (~sync_q[SYNC_STAGES-1] &  prev_q);
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_ctl_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ev,
  input  logic              pin_ev,
  input  logic [PORT_W-1:0] port_in,
  input  logic              chg_en,
  input  logic              snap_ld,
  input  logic              flag_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] flag_q
);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'((1 << SRC_N) - 1);

  logic [PORT_W-1:0] snap_q;
  logic [DATA_W-1:0] ev_vec;
  logic [DATA_W-1:0] kept;
  logic              chg_ev;

  assign chg_ev = chg_en && (port_in != snap_q);

  always_comb begin
    ev_vec          = '0;
    ev_vec[TMR_BIT] = tmr_ev;
    ev_vec[CHG_BIT] = chg_ev;
    ev_vec[PIN_BIT] = pin_ev;
    kept            = flag_wr ? (flag_q & wdata) : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      snap_q <= '0;
    end else begin
      flag_q <= (kept | ev_vec) & FLAG_MASK;
      if (snap_ld) snap_q <= port_in;
    end
  end

  // R3
  tmr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ev |=> flag_q[TMR_BIT]);

  // R5
  chg_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_en && !flag_q[CHG_BIT]) |=> !flag_q[CHG_BIT]);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !wdata[TMR_BIT] && !tmr_ev) |=> !flag_q[TMR_BIT]);
endmodule

// File: rtl/irq_req.sv
module irq_req
  import irq_ctl_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_HW = 8'h08,
  parameter logic [VEC_W-1:0] VEC_SW = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_pend,
  input  logic             swi_stb,
  input  logic             take_ready,
  output logic             take_valid,
  output logic [VEC_W-1:0] take_vector,
  output logic             load_hw
);
  logic swi_pend_q;
  logic sw_req;
  logic load_sw;

  assign sw_req  = swi_stb | swi_pend_q;
  assign load_sw = !take_valid && sw_req;
  assign load_hw = !take_valid && !sw_req && hw_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_valid  <= 1'b0;
      take_vector <= '0;
      swi_pend_q  <= 1'b0;
    end else begin
      if (load_sw) swi_pend_q <= 1'b0;
      else if (swi_stb) swi_pend_q <= 1'b1;

      if (take_valid) begin
        if (take_ready) take_valid <= 1'b0;
      end else if (load_sw) begin
        take_valid  <= 1'b1;
        take_vector <= VEC_SW;
      end else if (load_hw) begin
        take_valid  <= 1'b1;
        take_vector <= VEC_HW;
      end
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ready) |=> (take_valid && $stable(take_vector)));

  // R9
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> !take_valid);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned      PORT_W      = 8,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] VEC_HW      = 8'h08,
  parameter logic [VEC_W-1:0] VEC_SW      = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              edge_rise,
  input  logic              tmr_ovf,
  input  logic [PORT_W-1:0] port_in,
  input  logic              sleep,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              reti_stb,
  input  logic              swi_stb,
  output logic              take_valid,
  input  logic              take_ready,
  output logic [VEC_W-1:0]  take_vector,
  output logic              wake
);
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] flag_q;
  logic              pin_ev;
  logic              src_hit;
  logic              hw_pend;
  logic              load_hw;
  reg_addr_e         ra;

  assign ra = reg_addr_e'(reg_addr);

  irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .edge_rise(edge_rise), .edge_ev(pin_ev)
  );

  irq_flags #(.PORT_W(PORT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .tmr_ev(tmr_ovf), .pin_ev(pin_ev),
    .port_in(port_in), .chg_en(en_q[CHG_BIT]),
    .snap_ld(reg_rd && (ra == RA_PORT)),
    .flag_wr(reg_wr && (ra == RA_FLAGS)),
    .wdata(reg_wdata), .flag_q(flag_q)
  );

  assign src_hit = |(flag_q[SRC_N-1:0] & en_q[SRC_N-1:0]);
  assign hw_pend = en_q[GIE_BIT] && src_hit;
  assign wake    = sleep && src_hit;

  irq_req #(.VEC_HW(VEC_HW), .VEC_SW(VEC_SW)) u_req (
    .clk(clk), .rst_n(rst_n), .hw_pend(hw_pend), .swi_stb(swi_stb),
    .take_ready(take_ready), .take_valid(take_valid),
    .take_vector(take_vector), .load_hw(load_hw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      if (reg_wr && (ra == RA_ENABLE)) en_q <= reg_wdata;
      if (reti_stb) en_q[GIE_BIT] <= 1'b1;
      if (load_hw)  en_q[GIE_BIT] <= 1'b0;
    end
  end

  always_comb begin
    unique case (ra)
      RA_ENABLE: reg_rdata = en_q;
      RA_FLAGS:  reg_rdata = flag_q & en_q;
      RA_PORT:   reg_rdata = DATA_W'(port_in);
      default:   reg_rdata = '0;
    endcase
  end

  // R7
  hw_take_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(take_valid) && take_vector == VEC_HW) |-> !en_q[GIE_BIT]);

  // R10
  reti_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_stb && !load_hw) |=> en_q[GIE_BIT]);

  // R11
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[GIE_BIT] && !swi_stb && !take_valid && !u_req.swi_pend_q) |=> !take_valid);
endmodule

// File: tb/irq_ctl_tb.sv
module irq_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0, edge_rise = 1'b1, tmr_ovf = 1'b0, sleep = 1'b0;
  logic [7:0] port_in = 8'h00;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       reti_stb = 1'b0, swi_stb = 1'b0, take_ready = 1'b0;
  logic       take_valid, wake;
  logic [7:0] take_vector;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  irq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_rise(edge_rise),
    .tmr_ovf(tmr_ovf), .port_in(port_in), .sleep(sleep),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reti_stb(reti_stb),
    .swi_stb(swi_stb), .take_valid(take_valid), .take_ready(take_ready),
    .take_vector(take_vector), .wake(wake)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tpulse();
    tmr_ovf = 1'b1;
    step();
    tmr_ovf = 1'b0;
  endtask

  // {enable[7:0], timer pulse, flag write mask[7:0], expected flag read[7:0]}
  localparam logic [24:0] VEC [6] = '{
    {8'h00, 1'b1, 8'hFF, 8'h00},
    {8'h01, 1'b1, 8'hFF, 8'h01},
    {8'h01, 1'b1, 8'hFE, 8'h00},
    {8'h01, 1'b0, 8'hFF, 8'h00},
    {8'h05, 1'b1, 8'h01, 8'h01},
    {8'h04, 1'b1, 8'hFF, 8'h00}
  };

  initial begin
    logic [7:0] v;
    step(2);
    // R1 reset state
    check("R1 valid", {7'd0, take_valid}, 8'h00);
    check("R1 wake", {7'd0, wake}, 8'h00);
    rd(2'd0, v); check("R1 enable", v, 8'h00);
    rd(2'd1, v); check("R1 flags", v, 8'h00);
    rst_n = 1'b1;
    step();

    // R2 R3 R6 table walk
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, 8'h00);
      wr(2'd0, VEC[i][24:17]);
      if (VEC[i][16]) tpulse();
      wr(2'd1, VEC[i][15:8]);
      rd(2'd1, v);
      check($sformatf("R2/R6 row %0d", i), v, VEC[i][7:0]);
    end

    // R3 flag set while disabled
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    tpulse();
    wr(2'd0, 8'h01);
    rd(2'd1, v); check("R3 set while disabled", v, 8'h01);
    // R6 event wins over same-cycle clear
    tmr_ovf = 1'b1; wr(2'd1, 8'h00); tmr_ovf = 1'b0;
    rd(2'd1, v); check("R6 event wins", v, 8'h01);
    wr(2'd1, 8'h00);
    rd(2'd0, v); check("R2 enable readback", v, 8'h01);

    // R4 rising edge, sync latency
    wr(2'd0, 8'h04); edge_rise = 1'b1;
    pin_in = 1'b1;
    step(2); rd(2'd1, v); check("R4 not before third edge", v, 8'h00);
    step(); rd(2'd1, v); check("R4 rising sets", v, 8'h04);
    wr(2'd1, 8'h00);
    pin_in = 1'b0; step(5);
    rd(2'd1, v); check("R4 falling ignored", v, 8'h00);
    edge_rise = 1'b0;
    pin_in = 1'b1; step(5);
    rd(2'd1, v); check("R4 rising ignored", v, 8'h00);
    pin_in = 1'b0; step(4);
    rd(2'd1, v); check("R4 falling sets", v, 8'h04);
    wr(2'd1, 8'h00);

    // R5 port change
    wr(2'd0, 8'h02);
    port_in = 8'h10; step();
    rd(2'd1, v); check("R5 change sets", v, 8'h02);
    reg_addr = 2'd2; reg_rd = 1'b1; #1;
    check("R2 port read", reg_rdata, 8'h10);
    step(); reg_rd = 1'b0;
    wr(2'd1, 8'h00); step(2);
    rd(2'd1, v); check("R5 snapshot reloaded", v, 8'h00);
    wr(2'd0, 8'h00);
    port_in = 8'h33; step(3);
    reg_addr = 2'd2; reg_rd = 1'b1; step(); reg_rd = 1'b0;
    wr(2'd0, 8'h02); step(2);
    rd(2'd1, v); check("R5 disabled change ignored", v, 8'h00);

    // R7 R9 hardware take with back-pressure
    wr(2'd0, 8'h81);
    tpulse();
    check("R7 not yet valid", {7'd0, take_valid}, 8'h00);
    step();
    check("R7 valid", {7'd0, take_valid}, 8'h01);
    check("R7 vector", take_vector, 8'h08);
    rd(2'd0, v); check("R7 gie cleared", v, 8'h01);
    step(3);
    check("R9 held", {7'd0, take_valid}, 8'h01);
    check("R9 vector stable", take_vector, 8'h08);
    take_ready = 1'b1; step(); take_ready = 1'b0;
    check("R9 dropped after accept", {7'd0, take_valid}, 8'h00);
    step(3);
    check("R11 no request gie clear", {7'd0, take_valid}, 8'h00);
    check("R11 wake low awake", {7'd0, wake}, 8'h00);
    sleep = 1'b1; #1;
    check("R11 wake in sleep", {7'd0, wake}, 8'h01);
    sleep = 1'b0;

    // R10 return sets gie, request re-raised
    reti_stb = 1'b1; step(); reti_stb = 1'b0;
    rd(2'd0, v);
    check("R10 gie set", v, 8'h81);
    step();
    check("R10 request again", take_vector, 8'h08);
    check("R10 valid again", {7'd0, take_valid}, 8'h01);
    take_ready = 1'b1; step(); take_ready = 1'b0;
    wr(2'd1, 8'h00);
    reti_stb = 1'b1; wr(2'd0, 8'h01); reti_stb = 1'b0;
    rd(2'd0, v); check("R10 wins over write", v, 8'h81);
    wr(2'd0, 8'h01);

    // R8 software request alone, then tie with hardware
    swi_stb = 1'b1; step(); swi_stb = 1'b0;
    check("R8 sw vector", take_vector, 8'h02);
    check("R8 sw valid", {7'd0, take_valid}, 8'h01);
    take_ready = 1'b1; step(); take_ready = 1'b0;
    tpulse();
    wr(2'd0, 8'h81);
    swi_stb = 1'b1; step(); swi_stb = 1'b0;
    check("R8 sw wins tie", take_vector, 8'h02);
    rd(2'd0, v); check("R8 gie kept", v, 8'h81);
    take_ready = 1'b1; step(); take_ready = 1'b0;
    step();
    check("R8 hw follows", take_vector, 8'h08);
    take_ready = 1'b1; step(); take_ready = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule